// File: doc/BRIEF.md
# Flash Configuration Loader

This block lives in a small always-on controller next to an FPGA. It picks one of several configuration images held in a byte-wide parallel flash and streams it into the FPGA, one byte per configuration clock. The FPGA is loaded with eight data bits at a time, taken directly from the flash. An image is picked at power-up from a set of select switches. A push-button forces a reload from the factory image. The loader falls back to the factory image when the chosen user image is absent, and when a user load fails.

The loading sequence runs in a fixed order. The loader first probes the first byte of the chosen image. It then holds the start strobe low for a minimum time and waits for the FPGA to report it is ready. It then clocks out bytes from consecutive flash addresses until the FPGA reports completion. A fixed number of trailing clocks follow, so the FPGA can finish initialising. After that the flash read strobe is released and the status lamps show the outcome.

Top module: `cfg_loader`

## Requirements
- R1: While reset is low, `cfg_start_n`, `flash_rd_n` and `cfg_clk` sit at 1, 1 and 0, and all three lamps are off.
- R2: While `en_sw` is 0, the loader produces no start strobe, no flash read and no configuration clock. The button is also ignored in this state.
- R3: When `en_sw` is 1, a load starts. The value of `sel_sw` picks the image base. 0, 1 and 2 pick user images 0, 1 and 2 at 0x900000, 0xA00000 and 0xB00000 (a step of 0x100000). Every other value, including 7 (all switches open), picks the factory image at 0x200000.
- R4: A user image whose first byte reads 0xFF is treated as absent, and the factory image is loaded in its place.
- R5: A rising edge on `fact_btn` while enabled restarts the sequence at once with the factory image, whatever `sel_sw` holds.
- R6: `cfg_start_n` is held low for at least `NCFG_CYC` clocks (default 100, 2 us at 50 MHz). No data clock follows until `fpga_ok` is 1.
- R7: Each rising edge of `cfg_clk` carries one byte on `cfg_data`. The byte is stable across the edge. Successive bytes come from successive flash addresses, starting at the image base. `cfg_clk` has a period of two clocks.
- R8: Once `fpga_done` is seen, exactly `INIT_CLKS` further rising edges of `cfg_clk` are sent. The loader then releases `flash_rd_n` to 1 and lights `led_done`. `led_user` also lights when the loaded image was a user image.
- R9: If `fpga_ok` falls during a user load, the loader retries once with the factory image. If `fpga_ok` falls during a factory load, the loader lights `led_err` and stays idle until the button or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| sel_sw | input | 3 | Image select switches (1 = open) |
| en_sw | input | 1 | Loader enable switch (1 = open = enabled) |
| fact_btn | input | 1 | Force-factory push-button, active high |
| flash_d | input | 8 | Flash read data |
| flash_addr | output | ADDR_W | Flash byte address |
| flash_rd_n | output | 1 | Flash read strobe, active low |
| fpga_ok | input | 1 | FPGA status, high when ready and error-free |
| fpga_done | input | 1 | FPGA configuration complete |
| cfg_clk | output | 1 | Configuration data clock |
| cfg_data | output | 8 | Configuration data byte |
| cfg_start_n | output | 1 | Configuration start strobe, active low |
| led_done | output | 1 | Load finished lamp |
| led_user | output | 1 | User image loaded lamp |
| led_err | output | 1 | Load failed lamp |

## Verification
The bench models the FPGA at the ports. It scores every byte against the address it should have come from, so a loader that started at the wrong base, skipped an address or changed data on the clock edge shows up as data mismatches. It aims at a blank user image, switch codes outside the three user codes, a status drop in the middle of a user load, and a status drop in the middle of a factory load. A design that mishandled these would, in turn, load garbage, pick a wrong image, lock up instead of retrying, or loop forever instead of lighting the error lamp. It also counts trailing clocks after completion, measures the start strobe width, and presses the button both while the loader is disabled and after a user load has finished.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] FACT_BASE = 24'h200000,
  parameter logic [ADDR_W-1:0] USER_BASE = 24'h900000,
  parameter logic [ADDR_W-1:0] USER_STEP = 24'h100000,
  parameter int NCFG_CYC  = 100,
  parameter int INIT_CLKS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        sel_sw,
  input  logic              en_sw,
  input  logic              fact_btn,
  input  logic [7:0]        flash_d,
  output logic [ADDR_W-1:0] flash_addr,
  output logic              flash_rd_n,
  input  logic              fpga_ok,
  input  logic              fpga_done,
  output logic              cfg_clk,
  output logic [7:0]        cfg_data,
  output logic              cfg_start_n,
  output logic              led_done,
  output logic              led_user,
  output logic              led_err
);

  localparam int CMAX  = (NCFG_CYC > INIT_CLKS) ? NCFG_CYC : INIT_CLKS;
  localparam int CNT_W = $clog2(CMAX + 1) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_PROBE, S_PULSE, S_WAIT, S_LOAD, S_INIT, S_DONE, S_ERR
  } st_t;

  st_t              st;
  logic             ph;
  logic             is_fact;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       btn_q;
  logic             press;
  logic             fail_now;
  logic             user_sel;

  assign press    = btn_q[1] & ~btn_q[2];
  assign fail_now = (st == S_LOAD || st == S_INIT) && !fpga_ok;
  assign user_sel = (sel_sw < 3'd3);

  function automatic logic [ADDR_W-1:0] pick_base(input logic [2:0] s);
    if (s < 3'd3) return ADDR_W'(USER_BASE + ADDR_W'(s) * USER_STEP);
    return FACT_BASE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ph         <= 1'b0;
      is_fact    <= 1'b0;
      cnt        <= '0;
      btn_q      <= '0;
      flash_addr <= '0;
      cfg_clk    <= 1'b0;
      cfg_data   <= '0;
    end else begin
      btn_q <= {btn_q[1:0], fact_btn};
      if (!en_sw) begin
        st      <= S_IDLE;
        cfg_clk <= 1'b0;
      end else if (press) begin
        st         <= S_PULSE;
        is_fact    <= 1'b1;
        flash_addr <= FACT_BASE;
        cnt        <= '0;
        ph         <= 1'b0;
        cfg_clk    <= 1'b0;
      end else if (fail_now) begin
        cfg_clk <= 1'b0;
        ph      <= 1'b0;
        if (is_fact) begin
          st <= S_ERR;
        end else begin
          st         <= S_PULSE;
          is_fact    <= 1'b1;
          flash_addr <= FACT_BASE;
          cnt        <= '0;
        end
      end else begin
        case (st)
          S_IDLE: begin
            st         <= S_PROBE;
            flash_addr <= pick_base(sel_sw);
            is_fact    <= !user_sel;
            ph         <= 1'b0;
          end
          S_PROBE: begin
            if (!ph) begin
              ph <= 1'b1;
            end else begin
              ph  <= 1'b0;
              cnt <= '0;
              st  <= S_PULSE;
              if (flash_d == 8'hFF) begin
                is_fact    <= 1'b1;
                flash_addr <= FACT_BASE;
              end
            end
          end
          S_PULSE: begin
            if (cnt == CNT_W'(NCFG_CYC - 1)) st <= S_WAIT;
            else cnt <= cnt + 1'b1;
          end
          S_WAIT: begin
            if (fpga_ok) begin
              st <= S_LOAD;
              ph <= 1'b0;
            end
          end
          S_LOAD: begin
            if (!ph) begin
              cfg_clk <= 1'b0;
              ph      <= 1'b1;
              if (fpga_done) begin
                st  <= S_INIT;
                cnt <= '0;
              end else begin
                cfg_data <= flash_d;
              end
            end else begin
              cfg_clk    <= 1'b1;
              flash_addr <= flash_addr + 1'b1;
              ph         <= 1'b0;
            end
          end
          S_INIT: begin
            if (ph) begin
              cfg_clk <= 1'b1;
              cnt     <= cnt + 1'b1;
              ph      <= 1'b0;
            end else begin
              cfg_clk <= 1'b0;
              if (cnt == CNT_W'(INIT_CLKS)) st <= S_DONE;
              else ph <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign cfg_start_n = (st != S_PULSE);
  assign flash_rd_n  = !(st inside {S_PROBE, S_PULSE, S_WAIT, S_LOAD, S_INIT});
  assign led_done    = (st == S_DONE);
  assign led_user    = (st == S_DONE) && !is_fact;
  assign led_err     = (st == S_ERR);

  logic [CNT_W-1:0] lowrun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowrun <= '0;
    else if (cfg_start_n) lowrun <= '0;
    else if (lowrun != '1) lowrun <= lowrun + 1'b1;
  end

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_sw |=> (cfg_start_n && flash_rd_n && !cfg_clk)); // R2

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_start_n) && $past(en_sw)) |-> (lowrun >= CNT_W'(NCFG_CYC))); // R6

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> $stable(cfg_data)); // R7

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_clk) && $past(st) == S_LOAD) |-> (flash_addr == ADDR_W'($past(flash_addr) + 1'b1))); // R7

  AST_FAIL_REACT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && !fpga_ok && en_sw) |=> (!cfg_start_n || led_err)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (led_err && en_sw && !press) |=> led_err); // R9

endmodule

// File: tb/cfg_loader_tb.sv
`timescale 1ns/1ps
module cfg_loader_tb;
  localparam int NCFG    = 100;
  localparam int INIT_N  = 12;
  localparam int IMG_LEN = 24;
  localparam int FAULT_AT = 5;
  localparam logic [23:0] FACT = 24'h200000;

  logic clk = 0, rst_n = 0, en_sw = 0, fact_btn = 0;
  logic [2:0] sel_sw = 0;
  logic [7:0] flash_d;
  logic [23:0] flash_addr;
  logic flash_rd_n, fpga_ok, fpga_done, cfg_clk, cfg_start_n, led_done, led_user, led_err;
  logic [7:0] cfg_data;

  int total = 0, bad = 0;
  logic [2:0] valid = 3'b111;
  logic [3:0] fault_mask = 0;
  logic [23:0] exp_base [0:3];

  int starts, bytes_got, extra, mism, lowcnt, last_low, dly;
  logic faulted, p_clk, p_start;

  always #10 clk = ~clk;

  cfg_loader #(.NCFG_CYC(NCFG), .INIT_CLKS(INIT_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_sw(sel_sw), .en_sw(en_sw), .fact_btn(fact_btn),
    .flash_d(flash_d), .flash_addr(flash_addr), .flash_rd_n(flash_rd_n),
    .fpga_ok(fpga_ok), .fpga_done(fpga_done), .cfg_clk(cfg_clk), .cfg_data(cfg_data),
    .cfg_start_n(cfg_start_n), .led_done(led_done), .led_user(led_user), .led_err(led_err));

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [23:0] bexp(input logic [2:0] s, input logic [2:0] v);
    if (s < 3 && v[s]) return 24'h900000 + 24'(s) * 24'h100000;
    return FACT;
  endfunction

  function automatic logic [7:0] flash_model(input logic [23:0] a);
    for (int i = 0; i < 3; i++)
      if (a == 24'h900000 + 24'(i) * 24'h100000 && !valid[i]) return 8'hFF;
    return pat(a);
  endfunction

  assign flash_d = flash_model(flash_addr);

  always @(negedge clk) begin
    if (!rst_n) begin
      fpga_ok <= 0; fpga_done <= 0; starts <= 0; bytes_got <= 0; extra <= 0;
      mism <= 0; lowcnt <= 0; last_low <= 0; dly <= 0; faulted <= 0;
      p_clk <= 0; p_start <= 1;
    end else begin
      p_clk <= cfg_clk; p_start <= cfg_start_n;
      if (!cfg_start_n) begin
        fpga_ok <= 0; fpga_done <= 0; dly <= 0; faulted <= 0;
        lowcnt <= p_start ? 1 : lowcnt + 1;
        if (p_start) begin starts <= starts + 1; bytes_got <= 0; extra <= 0; end
      end else begin
        if (!p_start) last_low <= lowcnt;
        if (starts != 0 && !fpga_ok && !faulted) begin
          if (dly == 3) fpga_ok <= 1;
          dly <= dly + 1;
        end else if (fpga_ok && cfg_clk && !p_clk) begin
          if (!fpga_done) begin
            if (cfg_data !== pat(exp_base[starts-1] + 24'(bytes_got))) mism <= mism + 1;
            bytes_got <= bytes_got + 1;
            if (fault_mask[starts-1] && bytes_got == FAULT_AT) begin
              fpga_ok <= 0; faulted <= 1;
            end else if (bytes_got == IMG_LEN - 1) fpga_done <= 1;
          end else extra <= extra + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic power_up(input logic [2:0] s, input logic [2:0] v, input logic [3:0] fm, input logic en);
    en_sw = 0; rst_n = 0; sel_sw = s; valid = v; fault_mask = fm;
    exp_base[0] = bexp(s, v); exp_base[1] = FACT; exp_base[2] = FACT; exp_base[3] = FACT;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    en_sw = en;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(led_done || led_err) && n < 6000) begin @(negedge clk); n++; end
    chk(n < 6000, "R8 load ends", n, 6000);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_ok(input string tag, input bit user, input int nstarts);
    chk(led_done == 1, {tag, " R8 led_done"}, led_done, 1);
    chk(led_user == user, {tag, " R3 led_user"}, led_user, user);
    chk(led_err == 0, {tag, " R9 led_err"}, led_err, 0);
    chk(starts == nstarts, {tag, " R9 start count"}, starts, nstarts);
    chk(mism == 0, {tag, " R7 data mismatches"}, mism, 0);
    chk(bytes_got == IMG_LEN, {tag, " R7 byte count"}, bytes_got, IMG_LEN);
    chk(extra == INIT_N, {tag, " R8 trailing clocks"}, extra, INIT_N);
    chk(flash_rd_n == 1, {tag, " R8 flash released"}, flash_rd_n, 1);
    chk(last_low >= NCFG, {tag, " R6 start width"}, last_low, NCFG);
  endtask

  task automatic press_btn();
    fact_btn = 1; repeat (4) @(negedge clk); fact_btn = 0; repeat (20) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state
    en_sw = 1; rst_n = 0;
    repeat (3) @(negedge clk);
    chk(cfg_start_n == 1 && flash_rd_n == 1 && cfg_clk == 0, "R1 idle outputs",
        {cfg_start_n, flash_rd_n, cfg_clk}, 3'b110);
    chk({led_done, led_user, led_err} == 0, "R1 lamps off", {led_done, led_user, led_err}, 0);

    // R2: disabled, button ignored too
    power_up(3'd0, 3'b111, 4'd0, 1'b0);
    repeat (200) @(negedge clk);
    press_btn();
    repeat (200) @(negedge clk);
    chk(starts == 0, "R2 no start while disabled", starts, 0);
    chk(flash_rd_n == 1 && cfg_clk == 0, "R2 no flash or clock", {flash_rd_n, cfg_clk}, 2'b10);
    chk(led_done == 0, "R2 no done lamp", led_done, 0);

    // R3 directed selections
    power_up(3'd0, 3'b111, 4'd0, 1'b1); wait_end(); check_ok("user0", 1, 1);
    power_up(3'd7, 3'b111, 4'd0, 1'b1); wait_end(); check_ok("all open", 0, 1);
    power_up(3'd2, 3'b111, 4'd0, 1'b1); wait_end(); check_ok("user2", 1, 1);
    power_up(3'd4, 3'b111, 4'd0, 1'b1); wait_end(); check_ok("code4", 0, 1);

    // R4 blank user image
    power_up(3'd0, 3'b110, 4'd0, 1'b1); wait_end(); check_ok("R4 blank user0", 0, 1);

    // random selections and validity (R3, R4)
    for (int i = 0; i < 8; i++) begin
      logic [2:0] s, v;
      s = 3'($urandom % 8); v = 3'($urandom % 8);
      power_up(s, v, 4'd0, 1'b1); wait_end();
      check_ok("rand R3 R4", (s < 3 && v[s]), 1);
    end

    // R9 retry then factory
    power_up(3'd1, 3'b111, 4'b0001, 1'b1); wait_end(); check_ok("R9 retry", 0, 2);

    // R9 factory fails -> error, sticky
    power_up(3'd7, 3'b111, 4'b0001, 1'b1); wait_end();
    repeat (400) @(negedge clk);
    chk(led_err == 1, "R9 error lamp", led_err, 1);
    chk(led_done == 0, "R9 no done lamp", led_done, 0);
    chk(starts == 1, "R9 no further starts", starts, 1);

    // R5 button after user load
    power_up(3'd2, 3'b111, 4'd0, 1'b1); wait_end(); check_ok("before button", 1, 1);
    press_btn(); wait_end(); check_ok("R5 button factory", 0, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R8 act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule